// File: doc/BRIEF.md
# Five-Input Programmable Signal Synthesizer

This block turns five digital input signals into one output signal through a 32-bit truth table. Each input first goes through its own conditioner. The conditioner either passes the input level straight through, or it emits a one-cycle pulse when it sees a chosen transition. The five conditioned bits form a 5-bit index, with input i giving index bit i. The output register then captures the table bit at that index.

Because each conditioner is set on its own, one output can mix steady levels with transient events. One example is "input 2 rose while input 0 is high". Changing the table value changes the logic function from the next clock on.

An enable input gates the output. While the block is disabled, the edge-history registers keep tracking the inputs. Re-enabling the block therefore does not invent a transition.

Top module: `sig_synth5`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `dout` is 0; every edge-history bit resets to 0.
- R2: When `edge_mode[i]` is 0, index bit i equals `din[i]`. With `en` high, `dout` after a clock edge equals `table_val[index]`, using the inputs and table present before that edge (one cycle of latency).
- R3: When `edge_mode[i]` is 1 and `edge_sel[2i+1:2i]` is 0, index bit i is 1 for exactly one cycle when `din[i]` is 1 and was 0 at the previous clock edge.
- R4: Edge select value 1 makes index bit i 1 only when `din[i]` is 0 and was 1 at the previous clock edge.
- R5: Edge select value 2 makes index bit i 1 whenever `din[i]` differs from its value at the previous clock edge.
- R6: Edge select value 3 in edge mode makes index bit i constantly 0.
- R7: While `en` is low, `dout` is 0 on the following cycle, whatever the inputs and table are.
- R8: The edge-history registers update every cycle, including while `en` is low. Enabling the block with steady inputs creates no pulse. A transition that arrives in the same cycle as the enable is still seen.
- R9: A new `table_val` applies to the very next clock edge, with no extra delay.
- R10: Index bit order is fixed: `din[i]` drives index bit i, so `din` = k with all inputs in level mode selects `table_val[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Output enable; when low, the output is forced to 0 |
| din | input | 5 | The five input signals |
| edge_mode | input | 5 | Per input: 0 = level, 1 = edge detection |
| edge_sel | input | 10 | Per input, 2 bits at [2i+1:2i]: 0 rise, 1 fall, 2 both, 3 none |
| table_val | input | 32 | Truth table; bit k is the output for index k |
| dout | output | 1 | Synthesized output, registered |

## Verification
Two things can happen in the same cycle: a table reload and an edge pulse on the index, and an enable turn-on and an input transition. The bench changes `table_val` on every step of a sweep that also carries edge-mode inputs. It switches `en` on in the same cycle that all five inputs fall while they are in both-edge mode. Each result is compared with a bench model. That model keeps its own copy of the previous input sample and reads the table value from the same cycle.

// File: rtl/sig_synth_pkg.sv
package sig_synth_pkg;
   // Per-input transition selector, 2 bits per input
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_NONE = 2'd3
   } edge_kind_e;
endpackage

// File: rtl/sig_synth_cond.sv
module sig_synth_cond
   import sig_synth_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   input  logic       use_edge,
   input  logic [1:0] sel,
   output logic       cond
);
   logic prev_q;
   logic armed_q;
   logic rise, fall, pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= din;
         armed_q <= 1'b1;
      end
   end

   assign rise = din & ~prev_q;
   assign fall = ~din & prev_q;

   always_comb begin
      unique case (edge_kind_e'(sel))
         EDGE_RISE: pulse = rise;
         EDGE_FALL: pulse = fall;
         EDGE_BOTH: pulse = rise | fall;
         default:   pulse = 1'b0;
      endcase
   end

   assign cond = use_edge ? pulse : din;

   // R3
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      (use_edge && sel == 2'd0 && cond) |-> (din && !$past(din)));

   // R3
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (use_edge && sel == 2'd0 && cond) |=> !(use_edge && sel == 2'd0 && cond));

   // R4
   fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      (use_edge && sel == 2'd1 && cond) |-> (!din && $past(din)));

   // R5
   both_change_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      (use_edge && sel == 2'd2 && cond) |-> (din != $past(din)));
endmodule

// File: rtl/sig_synth_lut.sv
module sig_synth_lut #(
   parameter int N_IN = 5,
   localparam int TW = 1 << N_IN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [N_IN-1:0] idx,
   input  logic [TW-1:0]   table_val,
   output logic            dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= 1'b0;
      else        dout <= en & table_val[idx];
   end

   // R7
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !dout);

   // R2
   lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (dout == $past(table_val[idx])));
endmodule

// File: rtl/sig_synth5.sv
module sig_synth5 #(
   parameter int N_IN = 5,
   localparam int TW = 1 << N_IN,
   localparam int SW = 2 * N_IN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [N_IN-1:0] din,
   input  logic [N_IN-1:0] edge_mode,
   input  logic [SW-1:0]   edge_sel,
   input  logic [TW-1:0]   table_val,
   output logic            dout
);
   logic [N_IN-1:0] idx;

   if (N_IN < 1 || N_IN > 6) begin : g_bad_width
      $error("sig_synth5: N_IN must lie in 1..6");
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_cond
      sig_synth_cond u_cond (
         .clk      (clk),
         .rst_n    (rst_n),
         .din      (din[i]),
         .use_edge (edge_mode[i]),
         .sel      (edge_sel[2*i +: 2]),
         .cond     (idx[i])
      );
   end

   sig_synth_lut #(.N_IN(N_IN)) u_lut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .idx       (idx),
      .table_val (table_val),
      .dout      (dout)
   );

   // R1
   reset_low_chk: assert property (@(posedge clk) !rst_n |=> !dout);
endmodule

// File: tb/sig_synth5_bench.sv
module sig_synth5_bench;
   localparam int N  = 5;
   localparam int TW = 32;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic          en;
   logic [N-1:0]  din;
   logic [N-1:0]  edge_mode;
   logic [2*N-1:0] edge_sel;
   logic [TW-1:0] table_val;
   logic          dout;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [N-1:0] mprev;
   logic [31:0] lfsr = 32'h1D2C_3B4A;

   sig_synth5 u_sig_synth5 (
      .clk(clk), .rst_n(rst_n), .en(en), .din(din), .edge_mode(edge_mode),
      .edge_sel(edge_sel), .table_val(table_val), .dout(dout)
   );

   function automatic logic [N-1:0] model_idx(input logic [N-1:0] d, input logic [N-1:0] p,
                                              input logic [N-1:0] m, input logic [2*N-1:0] s);
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         if (!m[i]) r[i] = d[i];
         else begin
            case (s[2*i +: 2])
               2'd0:    r[i] = d[i] & ~p[i];
               2'd1:    r[i] = ~d[i] & p[i];
               2'd2:    r[i] = d[i] ^ p[i];
               default: r[i] = 1'b0;
            endcase
         end
      end
      return r;
   endfunction

   task automatic next_rand();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
   endtask

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: dout=%0b expected %0b (din=%b mode=%b sel=%b table=%h)",
                  tag, act, exp, din, edge_mode, edge_sel, table_val);
      end
   endtask

   // Inputs are driven at a falling edge; one rising edge later the output is compared
   task automatic step(input string tag);
      logic exp;
      exp = en & table_val[model_idx(din, mprev, edge_mode, edge_sel)];
      mprev = din;
      @(posedge clk);
      @(negedge clk);
      check(tag, dout, exp);
   endtask

   initial begin
      rst_n = 1'b0; en = 1'b0; din = '0; edge_mode = '0; edge_sel = '0; table_val = '0;
      mprev = '0;
      repeat (3) @(negedge clk);
      check("R1", dout, 1'b0);
      table_val = 32'hFFFF_FFFF; en = 1'b1;
      @(negedge clk);
      check("R1", dout, 1'b0);
      rst_n = 1'b1;
      en = 1'b0;
      step("R1");

      // R2 / R10: level mode, full index sweep
      en = 1'b1; edge_mode = '0;
      table_val = 32'hA5C3_0F96;
      for (int k = 0; k < TW; k++) begin din = N'(k); step("R2"); end
      for (int k = 0; k < TW; k++) begin
         table_val = 32'h1 << k;
         din = N'(k);         step("R10");
         din = N'((k + 1) % TW); step("R10");
      end

      // R3..R6: all inputs in edge mode, one selector at a time
      table_val = 32'h6B29_D1E4;
      edge_mode = '1;
      for (int s = 0; s < 4; s++) begin
         edge_sel = {N{2'(s)}};
         for (int t = 0; t < 64; t++) begin
            next_rand();
            din = lfsr[N-1:0];
            case (s)
               0: step("R3");
               1: step("R4");
               2: step("R5");
               default: step("R6");
            endcase
         end
      end
      // R6: held constant with toggling inputs and table all ones except index 0
      table_val = 32'hFFFF_FFFE;
      for (int t = 0; t < 8; t++) begin din = ~din; step("R6"); end

      // mixed modes with a table reload on every step (R9 coincides with pulses)
      edge_mode = 5'b10110;
      edge_sel  = {2'd2, 2'd1, 2'd0, 2'd3, 2'd1};
      for (int t = 0; t < 128; t++) begin
         next_rand();
         din = lfsr[N-1:0];
         next_rand();
         table_val = lfsr;
         step("R9");
      end

      // R7: disabled while inputs toggle in both-edge mode
      edge_mode = '1; edge_sel = {N{2'd2}}; table_val = 32'hFFFF_FFFF;
      en = 1'b0;
      for (int t = 0; t < 40; t++) begin next_rand(); din = lfsr[N-1:0]; step("R7"); end

      // R8: history kept during disable; steady enable gives no pulse
      din = '1; step("R8");
      step("R8");
      table_val = 32'h8000_0000;
      en = 1'b1; step("R8");
      step("R8");
      // R8: transition arriving with the enable is still seen
      en = 1'b0; din = '1; step("R8");
      en = 1'b1; din = '0; step("R8");
      step("R8");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule